// File: doc/BRIEF.md
# SPI Flash Command-Cycle Sequencer

This block runs one SPI flash command per software request. Software fills a small register file: a menu of eight permitted opcodes, a 2-bit type for each menu entry, two prefix opcodes, a 24-bit flash address and a 64-byte data buffer. It then writes the control word with the go bit set. The sequencer takes the opcode from the menu entry that the control word selects. If atomic mode is on, it first sends the selected prefix opcode in a frame of its own. It then sends the main opcode, the address when the type calls for one, and the data bytes. When the frame ends, it raises done.

The menu, type and prefix registers can be frozen by a sticky lock bit. After the lock is set, software can only run opcodes that were placed in the menu beforehand. The serial side is a single-chip-select SPI mode-0 master whose clock is derived from the system clock.

The control FSM has these states:

- `ST_IDLE`: waits for a start. It moves to `ST_PRE` when atomic mode is on, and to `ST_CMD` otherwise.
- `ST_PRE`: sends the prefix byte. It moves to `ST_GAP` when that byte is finished.
- `ST_GAP`: holds chip select high for a fixed number of cycles, then moves to `ST_CMD`.
- `ST_CMD`: sends the opcode. It moves to `ST_ADDR` for address types. Otherwise it moves to `ST_DATA` when data is enabled, or to `ST_END`.
- `ST_ADDR`: sends three address bytes. It then moves to `ST_DATA` or `ST_END`.
- `ST_DATA`: transfers count+1 bytes, then moves to `ST_END`.
- `ST_END`: lasts one cycle, in which done is set, then returns to `ST_IDLE`.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset every register reads 0: control, status, address, prefix, type, both menu words and lock.
- R2: The register map uses word indexes. Index 0 is control: bit 0 go, bit 1 atomic, bit 2 prefix select, bit 3 data enable, bits 6:4 menu index, bits 13:8 byte count minus one. Index 1 is status: bit 0 busy, bit 1 done, bit 2 error. Index 2 is the address, index 3 the prefixes, index 4 the types, indexes 5 and 6 the low and high menu words, index 7 the lock, and indexes 16 to 31 the buffer. Menu entry k is byte k of the 64-bit menu, with entry 0 in the lowest byte. That byte is the first byte of the main frame.
- R3: Entry k's type sits in bits 2k+1:2k of the type register. The codes are 0 read without address, 1 write without address, 2 read with address and 3 write with address. Only types 2 and 3 send the 24-bit address, MSB byte first, right after the opcode.
- R4: A data phase happens only when data enable is 1. It then moves count+1 bytes, up to 64.
- R5: Write types send buffer bytes from byte 0 upward. Byte n sits in buffer word n/4 at bits 8*(n mod 4)+7:8*(n mod 4).
- R6: Read types send 0x00 on the data line and store the received bytes into the buffer from byte 0 upward, with the same packing.
- R7: With atomic mode on, a one-byte frame carries prefix 1 (bits 7:0) when prefix select is 0, or prefix 2 (bits 15:8) when it is 1. Chip select then stays high for at least 2 SPI clocks before the main frame.
- R8: Busy reads 1 from the cycle after go until the last bit has been sent. Done is set in the cycle after busy clears. Writing 1 to the done or error bit clears that bit.
- R9: Writing go while busy sets error, leaves the control fields unchanged and sends nothing extra.
- R10: Writing 1 to the lock bit sets it until reset. While it is set, writes to the prefix, type and menu registers are ignored, and those registers still read back their held values.
- R11: SPI mode 0 is used. SCK idles low and has a period of 2*CLK_HALF system clocks. MOSI changes only when SCK falls, MSB first. MISO is sampled on rising SCK edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The embedded assertions check these properties on every cycle:

- SCK stays low while chip select is high.
- MOSI moves only on a falling SCK edge.
- Done follows the fall of busy by one cycle.
- Locked configuration registers never change.
- A go during a cycle raises error.
- The address byte index stays in range.

Only the directed scenarios, observed through a flash model on the serial pins, can show the following:

- The byte content and order of each frame.
- Whether the address and data phases are present for each type.
- Little-endian buffer packing on both reads and writes.
- Prefix selection and the width of the gap between the two frames.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_GAP,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_END
    } seq_state_e;

    localparam logic [2:0] RI_CTRL   = 3'd0;
    localparam logic [2:0] RI_STAT   = 3'd1;
    localparam logic [2:0] RI_ADDR   = 3'd2;
    localparam logic [2:0] RI_PREFIX = 3'd3;
    localparam logic [2:0] RI_TYPES  = 3'd4;
    localparam logic [2:0] RI_MENULO = 3'd5;
    localparam logic [2:0] RI_MENUHI = 3'd6;
    localparam logic [2:0] RI_LOCK   = 3'd7;
endpackage

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
    parameter int CLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

    logic          active_q;
    logic [DW-1:0] div_q;
    logic [3:0]    ph_q;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic          done_q;
    logic          tick;

    assign tick = (div_q == DW'(CLK_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            div_q    <= '0;
            ph_q     <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    sh_q     <= tx_byte;
                    ph_q     <= '0;
                    div_q    <= '0;
                end
            end else if (tick) begin
                div_q <= '0;
                ph_q  <= ph_q + 4'd1;
                if (!ph_q[0]) begin
                    rx_q <= {rx_q[6:0], miso};
                end else begin
                    sh_q <= {sh_q[6:0], 1'b0};
                    if (ph_q == 4'd15) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign sck     = active_q & ph_q[0];
    assign mosi    = sh_q[7];
    assign done    = done_q;
    assign rx_byte = rx_q;

    // R11
    mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && !$stable(mosi)) |-> $fell(sck));

    // R11
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active_q);
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
    import spi_seq_pkg::*;
#(
    parameter int DATA_BYTES = 64,
    parameter int CLK_HALF   = 2,
    localparam int BW        = $clog2(DATA_BYTES),
    localparam int GAP_CYC   = 4 * CLK_HALF,
    localparam int GW        = $clog2(GAP_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          atomic,
    input  logic          pre_sel,
    input  logic          data_en,
    input  logic [2:0]    menu_idx,
    input  logic [BW-1:0] cnt_m1,
    input  logic [63:0]   menu,
    input  logic [15:0]   types,
    input  logic [15:0]   prefix,
    input  logic [23:0]   addr,
    input  logic [7:0]    buf_rbyte,
    input  logic          sh_done,
    output logic [BW-1:0] byte_idx,
    output logic          buf_wr,
    output logic          sh_start,
    output logic [7:0]    sh_tx,
    output logic          cs_n,
    output logic          busy,
    output logic          cycle_end
);
    seq_state_e    state_q, state_d;
    logic [BW-1:0] idx_q;
    logic [GW-1:0] gap_q;
    logic          launch_q;
    logic          cs_n_q;
    logic [1:0]    cur_type;
    logic [7:0]    opcode;
    logic          is_read;
    logic          byte_st_d;

    assign cur_type = types[{menu_idx, 1'b0} +: 2];
    assign opcode   = menu[{menu_idx, 3'b000} +: 8];
    assign is_read  = ~cur_type[0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = atomic ? ST_PRE : ST_CMD;
            ST_PRE:  if (sh_done) state_d = ST_GAP;
            ST_GAP:  if (gap_q == GW'(GAP_CYC - 1)) state_d = ST_CMD;
            ST_CMD:  if (sh_done) state_d = cur_type[1] ? ST_ADDR
                                          : (data_en ? ST_DATA : ST_END);
            ST_ADDR: if (sh_done && idx_q == BW'(2))
                         state_d = data_en ? ST_DATA : ST_END;
            ST_DATA: if (sh_done && idx_q == cnt_m1) state_d = ST_END;
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign byte_st_d = (state_d == ST_PRE) || (state_d == ST_CMD) ||
                       (state_d == ST_ADDR) || (state_d == ST_DATA);

    // Registered outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            gap_q    <= '0;
            launch_q <= 1'b0;
            cs_n_q   <= 1'b1;
        end else begin
            launch_q <= byte_st_d && ((state_d != state_q) || sh_done);
            cs_n_q   <= ~byte_st_d;
            if (state_d != state_q) idx_q <= '0;
            else if (sh_done)       idx_q <= idx_q + BW'(1);
            gap_q <= (state_q == ST_GAP) ? gap_q + GW'(1) : '0;
        end
    end

    // Byte source for the shifter
    always_comb begin
        unique case (state_q)
            ST_PRE:  sh_tx = pre_sel ? prefix[15:8] : prefix[7:0];
            ST_CMD:  sh_tx = opcode;
            ST_ADDR: sh_tx = (idx_q == '0) ? addr[23:16]
                           : ((idx_q == BW'(1)) ? addr[15:8] : addr[7:0]);
            ST_DATA: sh_tx = is_read ? 8'h00 : buf_rbyte;
            default: sh_tx = 8'h00;
        endcase
    end

    assign sh_start  = launch_q;
    assign cs_n      = cs_n_q;
    assign byte_idx  = idx_q;
    assign buf_wr    = (state_q == ST_DATA) && sh_done && is_read;
    assign busy      = (state_q != ST_IDLE) && (state_q != ST_END);
    assign cycle_end = (state_q == ST_END);

    // R3
    addr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |-> (idx_q <= BW'(2)));

    // R7
    gap_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && $past(state_q) == ST_GAP) |-> cs_n);
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_seq_pkg::*;
#(
    parameter int DATA_BYTES = 64,
    parameter int CLK_HALF   = 2,
    localparam int WORDS     = DATA_BYTES / 4,
    localparam int WI_W      = $clog2(WORDS),
    localparam int RA_W      = WI_W + 1,
    localparam int BW        = $clog2(DATA_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            spi_sck,
    output logic            spi_cs_n,
    output logic            spi_mosi,
    input  logic            spi_miso
);
    logic [23:0]   addr_q;
    logic          atomic_q, psel_q, den_q;
    logic [2:0]    midx_q;
    logic [BW-1:0] cnt_q;
    logic [63:0]   menu_q;
    logic [15:0]   type_q, pref_q;
    logic          lock_q, done_q, err_q, go_q;
    logic [7:0]    buf_q [DATA_BYTES];

    logic          seq_busy, busy_all, cycle_end, buf_wr;
    logic          sh_start, sh_done, cs_n;
    logic [7:0]    sh_tx, sh_rx;
    logic [BW-1:0] byte_idx;
    logic          in_buf, ctrl_wr, go_pulse;
    logic [2:0]    ri;
    logic [WI_W-1:0] wi;

    assign in_buf   = reg_addr[RA_W-1];
    assign ri       = reg_addr[2:0];
    assign wi       = reg_addr[WI_W-1:0];
    assign busy_all = seq_busy | go_q;
    assign ctrl_wr  = reg_we && !in_buf && (ri == RI_CTRL);
    assign go_pulse = ctrl_wr && reg_wdata[0] && !busy_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0; atomic_q <= 1'b0; psel_q <= 1'b0; den_q <= 1'b0;
            midx_q <= '0; cnt_q <= '0; menu_q <= '0; type_q <= '0;
            pref_q <= '0; lock_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
            go_q   <= 1'b0;
        end else begin
            go_q <= go_pulse;
            if (reg_we && !in_buf) begin
                unique case (ri)
                    RI_CTRL: if (!busy_all) begin
                        atomic_q <= reg_wdata[1];
                        psel_q   <= reg_wdata[2];
                        den_q    <= reg_wdata[3];
                        midx_q   <= reg_wdata[6:4];
                        cnt_q    <= reg_wdata[8 +: BW];
                    end
                    RI_STAT: begin
                        if (reg_wdata[1]) done_q <= 1'b0;
                        if (reg_wdata[2]) err_q  <= 1'b0;
                    end
                    RI_ADDR:   addr_q <= reg_wdata[23:0];
                    RI_PREFIX: if (!lock_q) pref_q <= reg_wdata[15:0];
                    RI_TYPES:  if (!lock_q) type_q <= reg_wdata[15:0];
                    RI_MENULO: if (!lock_q) menu_q[31:0]  <= reg_wdata;
                    RI_MENUHI: if (!lock_q) menu_q[63:32] <= reg_wdata;
                    RI_LOCK:   if (reg_wdata[0]) lock_q <= 1'b1;
                    default: ;
                endcase
            end
            if (cycle_end) done_q <= 1'b1;
            if (ctrl_wr && reg_wdata[0] && busy_all) err_q <= 1'b1;
        end
    end

    // Data buffer: the sequencer's store wins over a register write
    always_ff @(posedge clk) begin
        if (reg_we && in_buf) begin
            for (int k = 0; k < 4; k++) begin
                buf_q[{wi, 2'(k)}] <= reg_wdata[8*k +: 8];
            end
        end
        if (buf_wr) buf_q[byte_idx] <= sh_rx;
    end

    always_comb begin
        reg_rdata = '0;
        if (in_buf) begin
            reg_rdata = {buf_q[{wi, 2'd3}], buf_q[{wi, 2'd2}],
                         buf_q[{wi, 2'd1}], buf_q[{wi, 2'd0}]};
        end else begin
            unique case (ri)
                RI_CTRL:   reg_rdata = 32'({cnt_q, 1'b0, midx_q, den_q,
                                            psel_q, atomic_q, 1'b0});
                RI_STAT:   reg_rdata = {29'd0, err_q, done_q, busy_all};
                RI_ADDR:   reg_rdata = {8'd0, addr_q};
                RI_PREFIX: reg_rdata = {16'd0, pref_q};
                RI_TYPES:  reg_rdata = {16'd0, type_q};
                RI_MENULO: reg_rdata = menu_q[31:0];
                RI_MENUHI: reg_rdata = menu_q[63:32];
                RI_LOCK:   reg_rdata = {31'd0, lock_q};
                default:   reg_rdata = '0;
            endcase
        end
    end

    spi_seq_ctrl #(.DATA_BYTES(DATA_BYTES), .CLK_HALF(CLK_HALF)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go_q), .atomic(atomic_q),
        .pre_sel(psel_q), .data_en(den_q), .menu_idx(midx_q),
        .cnt_m1(cnt_q), .menu(menu_q), .types(type_q), .prefix(pref_q),
        .addr(addr_q), .buf_rbyte(buf_q[byte_idx]), .sh_done(sh_done),
        .byte_idx(byte_idx), .buf_wr(buf_wr), .sh_start(sh_start),
        .sh_tx(sh_tx), .cs_n(cs_n), .busy(seq_busy), .cycle_end(cycle_end)
    );

    spi_seq_shifter #(.CLK_HALF(CLK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .done(sh_done),
        .rx_byte(sh_rx)
    );

    assign spi_cs_n = cs_n;

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(menu_q) && $stable(type_q) && $stable(pref_q)));

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_all) |=> done_q);

    // R9
    busy_go_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata[0] && busy_all) |=> err_q);

    // R11
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
endmodule

// File: tb/spi_cmd_seq_bench.sv
`timescale 1ns/1ps
module spi_cmd_seq_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    spi_cmd_seq #(.DATA_BYTES(64), .CLK_HALF(HALF)) u_spi_cmd_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #2.5 clk = ~clk;

    // Flash model: records frames, answers with a position-based pattern
    longint    cyc = 0;
    int        nfr = 0;
    int        frn [8];
    logic [7:0] frb [8][80];
    int        bitc = 0;
    logic [7:0] shin = '0;
    longint    t_rise = 0, gap_last = 0, last_sck = -1;
    longint    per_min = 1000, per_max = 0;

    function automatic logic [7:0] resp(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    always @(posedge clk) cyc++;
    always @(negedge spi_cs_n) begin
        bitc = 0;
        gap_last = cyc - t_rise;
        last_sck = -1;
        if (nfr < 8) frn[nfr] = 0;
        spi_miso <= #1 resp(0)[7];
    end
    always @(posedge spi_cs_n) begin
        if (nfr < 8) nfr++;
        t_rise = cyc;
    end
    always @(posedge spi_sck) begin
        if (!spi_cs_n && nfr < 8) begin
            shin = {shin[6:0], spi_mosi};
            bitc++;
            if (bitc % 8 == 0 && bitc <= 640) begin
                frb[nfr][bitc/8-1] = shin;
                frn[nfr] = bitc / 8;
            end
            if (last_sck >= 0) begin
                if (cyc - last_sck < per_min) per_min = cyc - last_sck;
                if (cyc - last_sck > per_max) per_max = cyc - last_sck;
            end
            last_sck = cyc;
        end
    end
    always @(negedge spi_sck) begin
        if (!spi_cs_n) spi_miso <= #1 resp(bitc / 8)[7 - bitc % 8];
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk(bit atomic, bit psel, bit den, int idx, int cnt);
        return 32'(1 | (atomic << 1) | (psel << 2) | (den << 3) | (idx << 4) | (cnt << 8));
    endfunction

    task automatic clear_cap();
        nfr = 0; per_min = 1000; per_max = 0;
        for (int i = 0; i < 8; i++) frn[i] = 0;
    endtask

    // Start a cycle and wait for done; checks busy/done timing (R8)
    task automatic run(input logic [31:0] ctl);
        logic [31:0] s;
        longint bfall = -1, dset = -1;
        wr(5'd1, 32'h6);
        clear_cap();
        wr(5'd0, ctl);
        rd(5'd1, s);
        chk("R8 busy after go", s[0], 1'b1);
        for (int i = 0; i < 6000 && dset < 0; i++) begin
            @(negedge clk);
            rd(5'd1, s);
            if (!s[0] && bfall < 0) bfall = cyc;
            if (s[1]) dset = cyc;
        end
        chk("R8 done one cycle after busy", 64'(dset - bfall), 64'd1);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(5'(a), d);
            chk("R1 reset value", d, 32'h0);
        end
    endtask

    task automatic t_setup();
        logic [31:0] d;
        wr(5'd5, 32'h05D80302);
        wr(5'd6, 32'hC79F01AB);
        wr(5'd4, 32'h463B);
        wr(5'd3, 32'h5006);
        rd(5'd5, d); chk("R2 menu low readback", d, 32'h05D80302);
        rd(5'd4, d); chk("R3 type readback", d, 32'h463B);
    endtask

    task automatic t_no_addr_no_data();
        run(mk(0, 0, 0, 3, 0));
        chk("R2 one frame", nfr, 1);
        chk("R4 opcode only", frn[0], 1);
        chk("R2 opcode from entry 3", frb[0][0], 8'h05);
        chk("R11 sck period min", per_min, 2 * HALF);
        chk("R11 sck period max", per_max, 2 * HALF);
    endtask

    task automatic t_read_addr();
        logic [31:0] d;
        wr(5'd2, 32'h00123456);
        run(mk(0, 0, 1, 1, 3));
        chk("R3 frame length", frn[0], 8);
        chk("R2 opcode", frb[0][0], 8'h03);
        chk("R3 addr hi", frb[0][1], 8'h12);
        chk("R3 addr mid", frb[0][2], 8'h34);
        chk("R3 addr lo", frb[0][3], 8'h56);
        chk("R6 idle mosi on read", frb[0][5], 8'h00);
        rd(5'd16, d);
        chk("R6 read packing", d, {resp(7), resp(6), resp(5), resp(4)});
    endtask

    task automatic t_read_no_addr();
        logic [31:0] d;
        run(mk(0, 0, 1, 6, 2));
        chk("R3 no address for type 0", frn[0], 4);
        chk("R2 opcode 9F", frb[0][0], 8'h9F);
        rd(5'd16, d);
        chk("R6 bytes from 0, byte 3 kept", d, {resp(7), resp(3), resp(2), resp(1)});
    endtask

    task automatic t_write_addr();
        wr(5'd16, 32'hDDCCBBAA);
        wr(5'd17, 32'h44332211);
        wr(5'd2, 32'h00ABCDEF);
        run(mk(0, 0, 1, 0, 5));
        chk("R5 frame length", frn[0], 10);
        chk("R3 addr bytes", {frb[0][1], frb[0][2], frb[0][3]}, 24'hABCDEF);
        chk("R5 write data order",
            {frb[0][4], frb[0][5], frb[0][6], frb[0][7], frb[0][8], frb[0][9]},
            48'hAABBCCDD1122);
    endtask

    task automatic t_write_no_data();
        run(mk(0, 0, 0, 5, 7));
        chk("R4 data disabled", frn[0], 1);
        chk("R2 opcode 01", frb[0][0], 8'h01);
    endtask

    task automatic t_atomic();
        wr(5'd2, 32'h00010000);
        run(mk(1, 0, 0, 2, 0));
        chk("R7 two frames", nfr, 2);
        chk("R7 prefix frame one byte", frn[0], 1);
        chk("R7 prefix 1", frb[0][0], 8'h06);
        chk("R7 main frame", {frb[1][0], frb[1][1], frb[1][2], frb[1][3]}, 32'hD8010000);
        chk("R7 gap >= 2 sck", gap_last >= 4 * HALF, 1'b1);
        run(mk(1, 1, 0, 7, 0));
        chk("R7 prefix 2", frb[0][0], 8'h50);
        chk("R7 main after prefix 2", frb[1][0], 8'hC7);
    endtask

    task automatic t_busy_go_and_full();
        logic [31:0] d;
        wr(5'd1, 32'h6);
        clear_cap();
        wr(5'd2, 32'h00000100);
        wr(5'd0, mk(0, 0, 1, 1, 63));
        repeat (10) @(negedge clk);
        wr(5'd0, mk(0, 0, 0, 3, 0));
        rd(5'd1, d);
        chk("R9 error on go while busy", d[2:0], 3'b101);
        rd(5'd0, d);
        chk("R9 control unchanged", d, mk(0, 0, 1, 1, 63) & 32'hFFFF_FFFE);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            rd(5'd1, d);
            if (d[1]) break;
        end
        repeat (40) @(negedge clk);
        chk("R9 nothing extra sent", nfr, 1);
        chk("R4 64 data bytes", frn[0], 68);
        chk("R9 first opcode kept", frb[0][0], 8'h03);
        rd(5'd31, d);
        chk("R6 last buffer word", d, {resp(67), resp(66), resp(65), resp(64)});
        wr(5'd1, 32'h6);
        rd(5'd1, d);
        chk("R8 write-one clears", d, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(5'd7, 32'h1);
        wr(5'd5, 32'hFFFFFFFF);
        wr(5'd4, 32'h0);
        wr(5'd3, 32'h0);
        rd(5'd5, d); chk("R10 menu held", d, 32'h05D80302);
        rd(5'd4, d); chk("R10 types held", d, 32'h463B);
        rd(5'd3, d); chk("R10 prefix held", d, 32'h5006);
        wr(5'd7, 32'h0);
        rd(5'd7, d); chk("R10 lock sticky", d, 32'h1);
        run(mk(0, 0, 0, 3, 0));
        chk("R10 menu still used", frb[0][0], 8'h05);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_no_addr_no_data();
        t_read_addr();
        t_read_no_addr();
        t_write_addr();
        t_write_no_data();
        t_atomic();
        t_busy_go_and_full();
        t_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule